// File: doc/BRIEF.md
# Filtered Timer Input Capture Unit

This block records the value of a free-running 16-bit timer into a capture register when a chosen edge arrives on an asynchronous input pin. The pin first passes through a two-flop synchronizer. It then goes through an optional four-sample digital filter that runs on the system clock. Last comes an edge detector that compares consecutive filtered samples. A capture sets a flag, and the flag can raise an interrupt request.

Software reads the captured count straight from the capture output. It clears the flag by writing a one to the clear bit, or by acknowledging the interrupt. There is no overrun protection: an event that arrives before software has read the last value overwrites it.

The edge polarity can be switched at run time, so high and low phases can be timed in turn for duty-cycle measurement. Capture is blocked while the timer uses the capture register as its period limit. A level that software drives onto the pin is captured just as an external edge would be.

Top module: `icu_capture`

## Requirements
- R1: With the filter bypassed, a pin change placed before clock edge E0 loads the capture register at edge E2, with the count value present just before E2. The count therefore equals the count seen at the pin change plus 2.
- R2: With the filter enabled, the same load happens exactly four cycles later, at edge E6, with the count seen at the pin change plus 6.
- R3: With the filter enabled, a pin pulse shorter than four system clock cycles produces no capture. The filtered level changes only after four consecutive synchronized samples agree.
- R4: When `edge_rise`=1 only rising filtered edges capture, and when it is 0 only falling ones capture. Changing `edge_rise` while the pin is steady causes no capture.
- R5: While `cap_inhibit`=1 no capture occurs, and `cap_value` and `cap_flag` keep their values.
- R6: A new capture overwrites `cap_value` even when `cap_flag` is still set.
- R7: A capture sets `cap_flag`. A cycle with `flag_wr`=1 and `flag_clr_bit`=1 clears it. A write with `flag_clr_bit`=0 leaves it unchanged.
- R8: `irq` is 1 exactly when `cap_flag`=1 and `irq_en`=1. A one-cycle `irq_ack` clears `cap_flag`.
- R9: After reset, `cap_value`=0, `cap_flag`=0 and `irq`=0.
- R10: When a capture and a flag clear fall in the same cycle, the capture wins and `cap_flag` ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin | input | 1 | Asynchronous capture input |
| tmr_count | input | 16 | Current timer count |
| filt_en | input | 1 | 1 = four-sample filter in path |
| edge_rise | input | 1 | 1 = rising edge captures, 0 = falling |
| cap_inhibit | input | 1 | 1 = capture register used as period limit, capture blocked |
| irq_en | input | 1 | Interrupt enable |
| flag_wr | input | 1 | Write strobe for the flag clear bit |
| flag_clr_bit | input | 1 | Written data; 1 clears the flag |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| cap_value | output | 16 | Capture register |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch several rules on every cycle. They check that the filter output moves only after four agreeing samples. They check that a capture event always leaves the flag set, even against a same-cycle clear. They check that the inhibit input freezes the capture register, and that a write-one or an acknowledge clears the flag while a write of zero leaves it alone.

Some behaviour only the bench scenarios can show. These are the exact latency in both filter settings, the count value that gets sampled, and rejection of short glitches. They also cover polarity selection and the absence of a capture when polarity changes, plus overwrite of an unread value.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int CNT_W = 16;

  // Edge hit for the selected polarity between two consecutive filtered levels.
  function automatic logic edge_hit(input logic lvl, input logic prev, input logic rise_sel);
    return rise_sel ? (lvl & ~prev) : (~lvl & prev);
  endfunction

  // True when every bit of a sample window agrees.
  function automatic logic window_agree(input logic [7:0] win, input int n);
    logic all1;
    logic all0;
    all1 = 1'b1;
    all0 = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (i < n) begin
        all1 = all1 & win[i];
        all0 = all0 & ~win[i];
      end
    end
    return all1 | all0;
  endfunction
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/icu_filter.sv
module icu_filter #(
  parameter int TAPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic lvl
);
  import icu_pkg::*;
  localparam int HW = TAPS - 1;

  logic [HW-1:0] hist;
  logic [7:0]    win;
  logic          agree;
  logic          filt_q;

  assign win   = 8'({hist, din});
  assign agree = window_agree(win, TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist   <= '0;
      filt_q <= 1'b0;
    end else begin
      hist <= {hist[HW-2:0], din};
      if (agree) filt_q <= din;
    end
  end

  assign lvl = en ? filt_q : din;

  generate
    if (TAPS == 4) begin : g_chk4
      // R3: filtered level only moves after four agreeing samples
      p_four_agree_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(din, 1) == filt_q) && ($past(din, 2) == filt_q)
                             && ($past(din, 3) == filt_q) && ($past(din, 4) == filt_q));
    end
  endgenerate
endmodule

// File: rtl/icu_edge.sv
module icu_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise_sel,
  output logic hit
);
  import icu_pkg::*;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  // Compares consecutive levels only, so a polarity change alone never hits.
  assign hit = edge_hit(lvl, prev_q, rise_sel);

  // R4: a hit always follows a level change of the selected polarity
  p_hit_polarity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (prev_q == rise_sel));
endmodule

// File: rtl/icu_capture.sv
module icu_capture #(
  parameter int CNT_W     = icu_pkg::CNT_W,
  parameter int SYNC_STG  = 2,
  parameter int FILT_TAPS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_pin,
  input  logic [CNT_W-1:0] tmr_count,
  input  logic             filt_en,
  input  logic             edge_rise,
  input  logic             cap_inhibit,
  input  logic             irq_en,
  input  logic             flag_wr,
  input  logic             flag_clr_bit,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] cap_value,
  output logic             cap_flag,
  output logic             irq
);
  logic pin_sync;
  logic filt_lvl;
  logic edge_evt;
  logic cap_fire;
  logic sw_clear;

  icu_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_pin), .dout(pin_sync));

  icu_filter #(.TAPS(FILT_TAPS)) u_filt (
    .clk(clk), .rst_n(rst_n), .en(filt_en), .din(pin_sync), .lvl(filt_lvl));

  icu_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(filt_lvl), .rise_sel(edge_rise), .hit(edge_evt));

  assign cap_fire = edge_evt & ~cap_inhibit;
  assign sw_clear = (flag_wr & flag_clr_bit) | irq_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_value <= '0;
      cap_flag  <= 1'b0;
    end else begin
      if (cap_fire) cap_value <= tmr_count;
      if (cap_fire)      cap_flag <= 1'b1;
      else if (sw_clear) cap_flag <= 1'b0;
    end
  end

  assign irq = cap_flag & irq_en;

  // R7, R10: a capture always leaves the flag set
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> cap_flag);
  // R5: inhibit freezes the capture register
  p_inhibit_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_inhibit |=> $stable(cap_value));
  // R7: write-one clears
  p_wr_one_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && flag_clr_bit && !cap_fire) |=> !cap_flag);
  // R7: write-zero keeps the flag
  p_wr_zero_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && flag_wr && !flag_clr_bit && !irq_ack) |=> cap_flag);
  // R8: acknowledge clears
  p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !cap_fire) |=> !cap_flag);
endmodule

// File: tb/icu_capture_test.sv
module icu_capture_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_pin = 1'b0;
  logic [15:0] tmr = 16'd0;
  logic        filt_en = 1'b0, edge_rise = 1'b1, cap_inhibit = 1'b0, irq_en = 1'b0;
  logic        flag_wr = 1'b0, flag_clr_bit = 1'b0, irq_ack = 1'b0;
  logic [15:0] cap_value;
  logic        cap_flag, irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tmr <= tmr + 16'd1;

  icu_capture uut (
    .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .tmr_count(tmr),
    .filt_en(filt_en), .edge_rise(edge_rise), .cap_inhibit(cap_inhibit),
    .irq_en(irq_en), .flag_wr(flag_wr), .flag_clr_bit(flag_clr_bit),
    .irq_ack(irq_ack), .cap_value(cap_value), .cap_flag(cap_flag), .irq(irq));

  typedef struct packed {
    logic       filt;
    logic       rise;
    logic       inh;
    logic       lvl;
    logic       hit;
    logic [3:0] dly;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2},  // R1 rising captures
    '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd0},  // R4 falling ignored
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'd0},  // R4 rising ignored
    '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},  // R4 falling captures
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd6},  // R2 filtered rising
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},  // R2 filtered falling
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd0},  // R5 inhibited
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0}   // R5 inhibited
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_wr = 1'b1; flag_clr_bit = 1'b1;
    @(negedge clk); flag_wr = 1'b0; flag_clr_bit = 1'b0;
  endtask

  initial begin
    logic [15:0] c;
    logic [15:0] vb;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cap_value == 16'd0, "R9 value", cap_value, 0);
    chk(cap_flag == 1'b0, "R9 flag", cap_flag, 0);
    chk(irq == 1'b0, "R9 irq", irq, 0);

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      filt_en = VECS[i].filt; edge_rise = VECS[i].rise; cap_inhibit = VECS[i].inh;
      clear_flag();
      repeat (8) @(negedge clk);
      chk(cap_flag == 1'b0, "R4 no capture on select change", cap_flag, 0);
      vb = cap_value;
      cap_pin = VECS[i].lvl;
      c = tmr;
      if (VECS[i].hit) begin
        repeat (VECS[i].dly) @(negedge clk);
        chk(cap_flag == 1'b0, VECS[i].filt ? "R2 early flag" : "R1 early flag", cap_flag, 0);
        @(negedge clk);
        chk(cap_flag == 1'b1, "R7 flag set", cap_flag, 1);
        chk(cap_value == c + 16'(VECS[i].dly), VECS[i].filt ? "R2 value" : "R1 value",
            cap_value, c + 16'(VECS[i].dly));
      end else begin
        repeat (10) @(negedge clk);
        chk(cap_flag == 1'b0, VECS[i].inh ? "R5 flag" : "R4 flag", cap_flag, 0);
        chk(cap_value == vb, VECS[i].inh ? "R5 value" : "R4 value", cap_value, vb);
      end
    end

    // R3 glitch rejection
    cap_inhibit = 1'b0; edge_rise = 1'b1; filt_en = 1'b1;
    clear_flag();
    repeat (8) @(negedge clk);
    cap_pin = 1'b1;
    repeat (3) @(negedge clk);
    cap_pin = 1'b0;
    repeat (12) @(negedge clk);
    chk(cap_flag == 1'b0, "R3 glitch rejected", cap_flag, 0);

    // R6 overwrite
    filt_en = 1'b0;
    repeat (4) @(negedge clk);
    cap_pin = 1'b1; repeat (6) @(negedge clk);
    cap_pin = 1'b0; repeat (6) @(negedge clk);
    cap_pin = 1'b1; c = tmr;
    repeat (3) @(negedge clk);
    chk(cap_value == c + 16'd2, "R6 overwrite", cap_value, c + 16'd2);
    chk(cap_flag == 1'b1, "R6 flag", cap_flag, 1);

    // R7 write zero no effect
    flag_wr = 1'b1; flag_clr_bit = 1'b0;
    @(negedge clk); flag_wr = 1'b0;
    chk(cap_flag == 1'b1, "R7 write zero", cap_flag, 1);

    // R8 irq gating and acknowledge
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq on", irq, 1);
    irq_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    irq_en = 1'b1; irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk(cap_flag == 1'b0, "R8 ack clears", cap_flag, 0);
    chk(irq == 1'b0, "R8 irq after ack", irq, 0);

    // R7 write one clears
    cap_pin = 1'b0; repeat (6) @(negedge clk);
    cap_pin = 1'b1; repeat (3) @(negedge clk);
    chk(cap_flag == 1'b1, "R7 set again", cap_flag, 1);
    clear_flag();
    chk(cap_flag == 1'b0, "R7 write one", cap_flag, 0);

    // R10 capture beats same-cycle clear
    cap_pin = 1'b0; repeat (6) @(negedge clk);
    cap_pin = 1'b1;
    repeat (2) @(negedge clk);
    flag_wr = 1'b1; flag_clr_bit = 1'b1;
    @(negedge clk);
    flag_wr = 1'b0; flag_clr_bit = 1'b0;
    chk(cap_flag == 1'b1, "R10 set wins", cap_flag, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule